// File: doc/BRIEF.md
# Top/Bottom Memory Region Chip Select Decoder

This block turns a 20-bit physical memory address into two active-low chip selects: one for a window that ends at the highest address (FFFFFh) and one for a window that starts at address 00000h. Each window has its own small control register that holds the window size, a wait-state count and an external-ready requirement. Software loads these registers through a one-cycle write port. For each bus cycle the block reports which select is active, how many wait states the cycle needs and whether external ready must be sampled.

The top window is live from reset with a 64 KB default (F0000h to FFFFFh), three wait states and external ready required, so the first instruction fetch at FFFF0h is decoded with no software set-up. The bottom window stays disabled until software writes its register for the first time. After that write it stays enabled until the next reset. The decode is captured on the address-valid strobe and held for the rest of the bus cycle. I/O cycles never assert either select.

Top module: `edge_region_sel`

## Requirements
- R1: While reset is held and after it is released, before any address strobe, both selects are high (inactive), `waitCnt` is 0 and `needReady` is 0.
- R2: Until the top register is written, a memory cycle at F0000h through FFFFFh asserts `topSelN` with `waitCnt` = 3 and `needReady` = 1. Address EFFFFh asserts no select.
- R3: The top size field `cfgData[4:3]` selects the window size: 0 = 64 KB, 1 = 128 KB, 2 = 256 KB, 3 = 512 KB. The window always ends at FFFFFh, so its lowest address is F0000h, E0000h, C0000h or 80000h.
- R4: `botSelN` never asserts until a write with `cfgSel` = 1 has occurred. Any such write, including all-zero data, enables the bottom window until the next reset.
- R5: Once enabled, the bottom window starts at 00000h, and its size is coded in `cfgData[4:3]` as for the top window. Its highest address is 0FFFFh, 1FFFFh, 3FFFFh or 7FFFFh.
- R6: `cfgData[1:0]` is the wait-state count and `cfgData[2]` = 1 means external ready is required. The outputs report the fields of the region that is selected. When no region is selected they are 0 and 0.
- R7: A cycle with `isIo` = 1 asserts neither select and reports `waitCnt` = 0 and `needReady` = 0.
- R8: The outputs are captured at the rising edge where `addrValid` is 1 and are held unchanged until the next such edge. A register write made in the same cycle as the strobe applies from the following strobe onward.
- R9: `topSelN` and `botSelN` are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | One-cycle register write strobe |
| cfgSel | input | 1 | Write target: 0 = top register, 1 = bottom register |
| cfgData | input | 5 | Register data: [4:3] size code, [2] ready required, [1:0] wait states |
| addrValid | input | 1 | Address strobe that starts a bus cycle |
| addr | input | 20 | Physical address |
| isIo | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| topSelN | output | 1 | Active-low select for the top window |
| botSelN | output | 1 | Active-low select for the bottom window |
| waitCnt | output | 2 | Wait states for the current cycle |
| needReady | output | 1 | External ready must be sampled in the current cycle |

## Verification
A vector table probes pairs of addresses that sit on each side of every window edge, for every size code of the top region and for two sizes of the bottom region. An off-by-one in the mask or a wrong size encoding therefore moves a select across a tested edge. Probes of low memory made before and after the first bottom write show whether the bottom select is enabled only by that write. Changing the wait and ready fields between writes shows whether the reported timing follows the region that hit or a stale register. Directed tests repeat the same probe as an I/O cycle, hold the address strobe low while the address changes, combine a write with a strobe in one cycle, and reset a second time to confirm that the bottom enable is cleared.

// File: rtl/edge_region_pkg.sv
package edge_region_pkg;
  parameter int ADDR_W = 20;
  parameter int BLK_W  = 16;   // log2 of the smallest window
  parameter int SIZE_W = 2;
  parameter int WAIT_W = 2;

  typedef struct packed {
    logic [SIZE_W-1:0] sizeCode;
    logic              needRdy;
    logic [WAIT_W-1:0] waitSt;
  } regionCfg_t;

  localparam int CFG_W = $bits(regionCfg_t);

  typedef struct packed {
    logic wrTop;
    logic wrBot;
    logic capture;
    logic memCycle;
    logic botArmed;
  } ctrlStrobes_t;

  localparam int REG_TOP = 0;
  localparam int REG_BOT = 1;
  localparam int N_REG   = 2;
endpackage

// File: rtl/edge_region_ctrl.sv
module edge_region_ctrl
  import edge_region_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic         cfgSel,
  input  logic         addrValid,
  input  logic         isIo,
  output ctrlStrobes_t strobes
);
  logic botArmedQ;

  // The bottom window is enabled by its first write and stays enabled until reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  botArmedQ <= 1'b0;
    else if (cfgWrEn && cfgSel) botArmedQ <= 1'b1;
  end

  always_comb begin
    strobes.wrTop    = cfgWrEn && !cfgSel;
    strobes.wrBot    = cfgWrEn && cfgSel;
    strobes.capture  = addrValid;
    strobes.memCycle = !isIo;
    strobes.botArmed = botArmedQ;
  end
endmodule

// File: rtl/edge_region_dp.sv
module edge_region_dp
  import edge_region_pkg::*;
#(
  parameter regionCfg_t TOP_RST_CFG = '{sizeCode: '0, needRdy: 1'b1, waitSt: '1}
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [ADDR_W-1:0] addr,
  output logic              topSelN,
  output logic              botSelN,
  output logic [WAIT_W-1:0] waitCnt,
  output logic              needReady
);
  regionCfg_t        cfgQ [N_REG];
  logic [N_REG-1:0]  hit;
  logic [N_REG-1:0]  selQ;
  logic [WAIT_W-1:0] waitQ;
  logic              rdyQ;

  // Mask of the address bits above the window size: these bits decide the match
  function automatic logic [ADDR_W-1:0] upperMask(input logic [SIZE_W-1:0] code);
    logic [ADDR_W-1:0] m;
    m = '1;
    for (int i = 0; i < ADDR_W; i++)
      if (i < BLK_W + int'(code)) m[i] = 1'b0;
    return m;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ[REG_TOP] <= TOP_RST_CFG;
      cfgQ[REG_BOT] <= '0;
    end else begin
      if (strobes.wrTop) cfgQ[REG_TOP] <= regionCfg_t'(cfgData);
      if (strobes.wrBot) cfgQ[REG_BOT] <= regionCfg_t'(cfgData);
    end
  end

  // One comparator per region: the top window needs all upper bits set, the bottom window needs all clear
  for (genvar g = 0; g < N_REG; g++) begin : gRegion
    logic [ADDR_W-1:0] mask;
    assign mask = upperMask(cfgQ[g].sizeCode);
    if (g == REG_TOP) begin : gTop
      assign hit[g] = strobes.memCycle && ((addr & mask) == mask);
    end else begin : gBot
      assign hit[g] = strobes.memCycle && strobes.botArmed && ((addr & mask) == '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '0;
      waitQ <= '0;
      rdyQ  <= 1'b0;
    end else if (strobes.capture) begin
      selQ <= hit;
      if (hit[REG_TOP]) begin
        waitQ <= cfgQ[REG_TOP].waitSt;
        rdyQ  <= cfgQ[REG_TOP].needRdy;
      end else if (hit[REG_BOT]) begin
        waitQ <= cfgQ[REG_BOT].waitSt;
        rdyQ  <= cfgQ[REG_BOT].needRdy;
      end else begin
        waitQ <= '0;
        rdyQ  <= 1'b0;
      end
    end
  end

  assign topSelN   = !selQ[REG_TOP];
  assign botSelN   = !selQ[REG_BOT];
  assign waitCnt   = waitQ;
  assign needReady = rdyQ;
endmodule

// File: rtl/edge_region_sel.sv
module edge_region_sel
  import edge_region_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              isIo,
  output logic              topSelN,
  output logic              botSelN,
  output logic [WAIT_W-1:0] waitCnt,
  output logic              needReady
);
  ctrlStrobes_t strobes;

  edge_region_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .addrValid(addrValid), .isIo(isIo), .strobes(strobes)
  );

  edge_region_dp dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgData(cfgData), .addr(addr),
    .topSelN(topSelN), .botSelN(botSelN), .waitCnt(waitCnt), .needReady(needReady)
  );
endmodule

// File: rtl/edge_region_chk.sv
module edge_region_chk
  import edge_region_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic              cfgSel,
  input logic [CFG_W-1:0]  cfgData,
  input logic              addrValid,
  input logic [ADDR_W-1:0] addr,
  input logic              isIo,
  input logic              topSelN,
  input logic              botSelN,
  input logic [WAIT_W-1:0] waitCnt,
  input logic              needReady
);
  logic topWritten, botWritten;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topWritten <= 1'b0;
      botWritten <= 1'b0;
    end else if (cfgWrEn) begin
      if (cfgSel) botWritten <= 1'b1;
      else        topWritten <= 1'b1;
    end
  end

  // R2: default top window before any top write
  a_r2_boot_window: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !isIo && !topWritten && (&addr[ADDR_W-1:BLK_W]))
      |=> (!topSelN && waitCnt == '1 && needReady));

  // R4: bottom select stays off until its register has been written
  a_r4_bot_dead: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !botWritten) |=> botSelN);

  // R7: I/O cycles select nothing
  a_r7_io_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && isIo) |=> (topSelN && botSelN && waitCnt == '0 && !needReady));

  // R8: outputs hold between strobes
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> ($stable(topSelN) && $stable(botSelN) && $stable(waitCnt) && $stable(needReady)));

  // R9: never both selects
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (topSelN || botSelN));

  // R6: idle cycle reports no timing
  a_r6_idle_timing: assert property (@(posedge clk) disable iff (!rstN)
    (topSelN && botSelN) |-> (waitCnt == '0 && !needReady));

  // R1: reset state
  always_comb begin
    if (!rstN) a_r1_reset_idle: assert (topSelN && botSelN && waitCnt == '0 && !needReady);
  end

  logic unusedData;
  assign unusedData = ^cfgData;
endmodule

bind edge_region_sel edge_region_chk chk_i (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
  .addrValid(addrValid), .addr(addr), .isIo(isIo), .topSelN(topSelN),
  .botSelN(botSelN), .waitCnt(waitCnt), .needReady(needReady)
);

// File: tb/edge_region_sel_tb.sv
module edge_region_sel_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [4:0]  cfgData = '0;
  logic        addrValid = 1'b0;
  logic [19:0] addr = '0;
  logic        isIo = 1'b0;
  logic        topSelN, botSelN, needReady;
  logic [1:0]  waitCnt;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  edge_region_sel dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .addrValid(addrValid), .addr(addr), .isIo(isIo), .topSelN(topSelN),
    .botSelN(botSelN), .waitCnt(waitCnt), .needReady(needReady)
  );

  typedef struct packed {
    logic        isWr;
    logic        sel;
    logic [4:0]  data;
    logic [19:0] addr;
    logic        io;
    logic        expTop;
    logic        expBot;
    logic [1:0]  expWait;
    logic        expRdy;
    logic [3:0]  req;
  } vec_t;

  localparam int N_VEC = 22;
  // cfgData = {size[1:0], readyRequired, wait[1:0]}
  localparam vec_t VECS [N_VEC] = '{
    '{1'b0, 1'b0, 5'b00000, 20'hFFFF0, 1'b0, 1'b1, 1'b0, 2'd3, 1'b1, 4'd2},  // R2 boot fetch
    '{1'b0, 1'b0, 5'b00000, 20'hF0000, 1'b0, 1'b1, 1'b0, 2'd3, 1'b1, 4'd2},  // R2 low edge
    '{1'b0, 1'b0, 5'b00000, 20'hEFFFF, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd2},  // R2 just below
    '{1'b0, 1'b0, 5'b00000, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd4},  // R4 bottom dead
    '{1'b0, 1'b0, 5'b00000, 20'hFFFF0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 4'd7},  // R7 io
    '{1'b1, 1'b1, 5'b00000, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd4},  // R4 zero write arms
    '{1'b0, 1'b0, 5'b00000, 20'h00000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 4'd4},  // R4 now live
    '{1'b0, 1'b0, 5'b00000, 20'h0FFFF, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 4'd5},  // R5 64K top edge
    '{1'b0, 1'b0, 5'b00000, 20'h10000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd5},  // R5 just above
    '{1'b1, 1'b1, 5'b11110, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd5},  // R5 512K w2 rdy
    '{1'b0, 1'b0, 5'b00000, 20'h7FFFF, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 4'd6},  // R6 bottom fields
    '{1'b0, 1'b0, 5'b00000, 20'h80000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd5},  // R5 just above
    '{1'b1, 1'b0, 5'b01001, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd3},  // R3 128K w1
    '{1'b0, 1'b0, 5'b00000, 20'hE0000, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 4'd3},  // R3
    '{1'b0, 1'b0, 5'b00000, 20'hDFFFF, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd3},  // R3
    '{1'b1, 1'b0, 5'b10100, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd3},  // R3 256K w0 rdy
    '{1'b0, 1'b0, 5'b00000, 20'hC0000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 4'd6},  // R6 top fields
    '{1'b0, 1'b0, 5'b00000, 20'hBFFFF, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd3},  // R3
    '{1'b1, 1'b0, 5'b11011, 20'h00000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd3},  // R3 512K w3
    '{1'b0, 1'b0, 5'b00000, 20'h80000, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 4'd3},  // R3
    '{1'b0, 1'b0, 5'b00000, 20'h7FFFF, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 4'd9},  // R9 adjacent
    '{1'b0, 1'b0, 5'b00000, 20'h00000, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 4'd7}   // R7 io low
  };

  task automatic check(input int req, input logic eTop, input logic eBot,
                       input logic [1:0] eWait, input logic eRdy, input string what);
    logic [4:0] act, exp;
    act = {!topSelN, !botSelN, waitCnt, needReady};
    exp = {eTop, eBot, eWait, eRdy};
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL R%0d %s: actual sel{top,bot}/wait/rdy=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [4:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic probe(input logic [19:0] a, input logic io);
    @(negedge clk);
    addrValid = 1'b1; addr = a; isIo = io;
    @(negedge clk);
    addrValid = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    // R1: held in reset, then released
    repeat (3) @(negedge clk);
    check(1, 1'b0, 1'b0, 2'd0, 1'b0, "in reset");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(1, 1'b0, 1'b0, 2'd0, 1'b0, "after release r1_");

    for (int i = 0; i < N_VEC; i++) begin
      if (VECS[i].isWr) writeReg(VECS[i].sel, VECS[i].data);
      else begin
        probe(VECS[i].addr, VECS[i].io);
        check(int'(VECS[i].req), VECS[i].expTop, VECS[i].expBot,
              VECS[i].expWait, VECS[i].expRdy, $sformatf("vector %0d", i));
      end
    end

    // R8: strobe low, address moves into the top window, outputs hold the bottom result
    probe(20'h00010, 1'b0);
    @(negedge clk); addr = 20'hFFFFF;
    @(negedge clk); @(negedge clk);
    check(8, 1'b0, 1'b1, 2'd2, 1'b1, "hold without strobe");

    // R8: write of 64K bottom in the same cycle as a strobe at 20000h uses the old 512K window
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 1'b1; cfgData = 5'b00000;
    addrValid = 1'b1; addr = 20'h20000; isIo = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b0; addrValid = 1'b0;
    check(8, 1'b0, 1'b1, 2'd2, 1'b1, "same-cycle write uses old cfg");
    probe(20'h20000, 1'b0);
    check(8, 1'b0, 1'b0, 2'd0, 1'b0, "new cfg next strobe");

    // R1/R4: second reset clears the bottom enable and restores the top default
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check(1, 1'b0, 1'b0, 2'd0, 1'b0, "second reset");
    rstN = 1'b1;
    probe(20'h00000, 1'b0);
    check(4, 1'b0, 1'b0, 2'd0, 1'b0, "bottom dead after reset");
    probe(20'hF8000, 1'b0);
    check(2, 1'b1, 1'b0, 2'd3, 1'b1, "top default after reset");
    probe(20'h80000, 1'b0);
    check(2, 1'b0, 1'b0, 2'd0, 1'b0, "top back to 64K");

    finish();
  end
endmodule